// File: doc/BRIEF.md
# Digit-Serial GF(2^191) Multiplier

This block performs arithmetic on elements of the binary field GF(2^191) in polynomial basis, reduced modulo the fixed trinomial f(x) = x^191 + x^9 + 1. A multiply keeps the first operand at full width. It consumes the second operand one digit of DIGIT_W bits per clock, starting with the most significant digit. Each step shifts the accumulator up by one digit and XORs in the carry-less product of the full operand with the current digit. The accumulator is folded back below x^191 at the start of every step, so its width stays at 191 + DIGIT_W bits. One extra cycle at the end does the last fold.

Squaring is a separate single-cycle operation. It places zeros between the operand bits and then reduces the result. Field addition is a single-cycle XOR. A caller places the operands and an opcode on the inputs and pulses start. It then waits for the done pulse and reads the result, which stays on the output until the next accepted command.

Top module: `gfm_digit_mul`

## Requirements
- R1: While reset is high and on the first cycle after it, busy and done are low and result is all zeros.
- R2: With op = 2'b01 (multiply), the result is a(x)·b(x) mod x^191 + x^9 + 1. Bit i of a port is the coefficient of x^i.
- R3: A multiply raises busy right after the clock edge that samples start. done rises, and busy falls, exactly ceil(191/DIGIT_W)+1 edges after that edge.
- R4: With op = 2'b10 (square), result becomes a(x)^2 mod f(x), and done rises at the same edge that samples start. busy stays low.
- R5: With op = 2'b00 (add), result becomes a XOR b, and done rises at the same edge that samples start. busy stays low.
- R6: done is high for one cycle per command. Once a command completes, result holds its value until the next accepted start.
- R7: A start seen while busy is high is ignored. The running multiply finishes with its own operands and latency, and no extra done follows.
- R8: op = 2'b11 is reserved. A start with that code raises neither busy nor done and leaves result unchanged.
- R9: Multiply operands are captured at the start edge. Changes on a and b during the multiply do not change its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe, sampled only while idle |
| op | input | 2 | Command: 00 add, 01 multiply, 10 square, 11 reserved |
| a | input | 191 | Full-width operand (also the square input) |
| b | input | 191 | Digit-serial operand of a multiply, second addend |
| busy | output | 1 | High while a multiply is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 191 | Last completed field result |

## Verification
The bench builds the block with DIGIT_W = 8, which gives 24 digits. The top digit then carries only seven real operand bits and one zero pad. This setting exercises the padded-digit path and the longest digit loop, and so the largest latency window for the ignored-start and operand-change checks. Random and directed operands include x^190·x^190, which needs a second fold. Products are compared with a bit-serial reference, and squares are compared with both the reference and the block's own multiply of an operand by itself.

// File: rtl/gfm_pkg.sv
package gfm_pkg;
  localparam int FIELD_M  = 191;
  localparam int POLY_MID = 9;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_MUL = 2'b01,
    OP_SQR = 2'b10,
    OP_NOP = 2'b11
  } gfm_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_FIN  = 2'b10
  } gfm_state_e;
endpackage

// File: rtl/gfm_reduce.sv
// Folds any polynomial of IN_W coefficients back below x^M using
// x^M = x^MID + 1. Top bits are handled first so cascaded folds settle.
module gfm_reduce #(
  parameter int M    = 191,
  parameter int MID  = 9,
  parameter int IN_W = 199
) (
  input  logic [IN_W-1:0] wide,
  output logic [M-1:0]    narrow
);
  logic [IN_W-1:0] work;

  always_comb begin
    work = wide;
    for (int i = IN_W - 1; i >= M; i--) begin
      if (work[i]) begin
        work[i-M]     = ~work[i-M];
        work[i-M+MID] = ~work[i-M+MID];
      end
    end
    narrow = work[M-1:0];
  end
endmodule

// File: rtl/gfm_pp.sv
// Carry-less product of a full-width operand and one digit.
module gfm_pp #(
  parameter int M = 191,
  parameter int W = 8
) (
  input  logic [M-1:0]     a,
  input  logic [W-1:0]     digit,
  output logic [M+W-2:0]   prod
);
  localparam int PP_W = M + W - 1;

  logic [PP_W-1:0] rows [W];

  for (genvar k = 0; k < W; k++) begin : g_row
    assign rows[k] = (PP_W'(a) & {PP_W{digit[k]}}) << k;
  end

  always_comb begin
    prod = '0;
    for (int k = 0; k < W; k++) prod = prod ^ rows[k];
  end
endmodule

// File: rtl/gfm_square.sv
// Squaring: coefficients move to even positions, then full reduction.
module gfm_square #(
  parameter int M   = 191,
  parameter int MID = 9
) (
  input  logic [M-1:0] a,
  output logic [M-1:0] sq
);
  localparam int SP_W = 2 * M - 1;

  logic [SP_W-1:0] spread;

  always_comb begin
    spread = '0;
    for (int i = 0; i < M; i++) spread[2*i] = a[i];
  end

  gfm_reduce #(.M(M), .MID(MID), .IN_W(SP_W)) u_sq_red (
    .wide   (spread),
    .narrow (sq)
  );
endmodule

// File: rtl/gfm_digit_mul.sv
module gfm_digit_mul
  import gfm_pkg::*;
#(
  parameter int DIGIT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [1:0]           op,
  input  logic [FIELD_M-1:0]   a,
  input  logic [FIELD_M-1:0]   b,
  output logic                 busy,
  output logic                 done,
  output logic [FIELD_M-1:0]   result
);
  localparam int M     = FIELD_M;
  localparam int ND    = (M + DIGIT_W - 1) / DIGIT_W;
  localparam int BPAD  = ND * DIGIT_W;
  localparam int ACC_W = M + DIGIT_W;
  localparam int CNT_W = $clog2(ND + 1);
  localparam int LEN_W = $clog2(ND + 2) + 1;

  gfm_state_e         state_q;
  logic [M-1:0]       a_q;
  logic [BPAD-1:0]    b_q;
  logic [ACC_W-1:0]   acc_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               done_q;
  logic [M-1:0]       res_q;

  logic [DIGIT_W-1:0] digit;
  logic [M+DIGIT_W-2:0] pp;
  logic [M-1:0]       acc_fold;
  logic [ACC_W-1:0]   acc_next;
  logic [M-1:0]       sq_val;
  logic [BPAD-1:0]    b_ext;

  assign b_ext = BPAD'(b);
  assign digit = b_q[BPAD-1 -: DIGIT_W];

  gfm_pp #(.M(M), .W(DIGIT_W)) u_pp (
    .a     (a_q),
    .digit (digit),
    .prod  (pp)
  );

  gfm_reduce #(.M(M), .MID(POLY_MID), .IN_W(ACC_W)) u_acc_red (
    .wide   (acc_q),
    .narrow (acc_fold)
  );

  gfm_square #(.M(M), .MID(POLY_MID)) u_sq (
    .a  (a),
    .sq (sq_val)
  );

  assign acc_next = {acc_fold, {DIGIT_W{1'b0}}} ^ ACC_W'(pp);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      a_q     <= '0;
      b_q     <= '0;
      acc_q   <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            case (gfm_op_e'(op))
              OP_ADD: begin
                res_q  <= a ^ b;
                done_q <= 1'b1;
              end
              OP_SQR: begin
                res_q  <= sq_val;
                done_q <= 1'b1;
              end
              OP_MUL: begin
                a_q     <= a;
                b_q     <= b_ext;
                acc_q   <= '0;
                cnt_q   <= '0;
                state_q <= ST_RUN;
              end
              default: ;
            endcase
          end
        end
        ST_RUN: begin
          acc_q <= acc_next;
          b_q   <= b_q << DIGIT_W;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(ND - 1)) state_q <= ST_FIN;
        end
        ST_FIN: begin
          res_q   <= acc_fold;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign done   = done_q;
  assign result = res_q;

  // Length of each busy window, used to check multiply latency.
  logic [LEN_W-1:0] run_len;
  always_ff @(posedge clk) begin
    if (rst)       run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!busy && !done && result == '0));

  a_r3_busy_on_mul: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && op == 2'b01) |=> busy);

  a_r3_done_at_end: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done && run_len == LEN_W'(ND + 1)));

  a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r6_result_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(result));

  a_r8_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && op == 2'b11) |=> (!busy && !done && $stable(result)));
endmodule

// File: tb/test_gfm_digit_mul.sv
module test_gfm_digit_mul;
  localparam int CLK_PERIOD = 10;
  localparam int DIGIT_W    = 8;
  localparam int ND         = (191 + DIGIT_W - 1) / DIGIT_W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [1:0]   op = 2'b00;
  logic [190:0] a = '0;
  logic [190:0] b = '0;
  logic         busy;
  logic         done;
  logic [190:0] result;

  int nchk  = 0;
  int nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gfm_digit_mul #(.DIGIT_W(DIGIT_W)) i_gfm_digit_mul (
    .clk(clk), .rst(rst), .start(start), .op(op), .a(a), .b(b),
    .busy(busy), .done(done), .result(result)
  );

  function automatic logic [190:0] ref_mul(logic [190:0] x, logic [190:0] y);
    logic [190:0] c;
    logic top;
    c = '0;
    for (int i = 190; i >= 0; i--) begin
      top = c[190];
      c = {c[189:0], 1'b0};
      if (top) begin c[0] = ~c[0]; c[9] = ~c[9]; end
      if (y[i]) c = c ^ x;
    end
    return c;
  endfunction

  function automatic logic [190:0] rnd191();
    logic [191:0] t;
    t = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
    return t[190:0];
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [190:0] act, input logic [190:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] o, input logic [190:0] x,
                        input logic [190:0] y, output logic [190:0] r,
                        output int lat, output logic busy0);
    @(negedge clk);
    start = 1'b1; op = o; a = x; b = y;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    busy0 = busy;
    while (!done && lat < 2000) begin
      @(negedge clk);
      lat++;
    end
    r = result;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    logic [190:0] x, y, r, e, r2, held;
    int lat;
    logic b0;
    bit quiet;
    void'($urandom(32'd4711));

    repeat (3) @(negedge clk);
    check(!busy && !done && result == '0, "R1 reset outputs", result, '0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && result == '0, "R1 after reset", result, '0);

    // R2/R3 directed corners
    run_op(2'b01, 191'd1, 191'b1 << 190, r, lat, b0);
    check(r == (191'b1 << 190), "R2 one times x^190", r, 191'b1 << 190);
    check(lat == ND + 1, "R3 latency", 191'(lat), 191'(ND + 1));
    check(b0 == 1'b1, "R3 busy after start", 191'(b0), 191'd1);
    x = 191'b1 << 190;
    run_op(2'b01, x, x, r, lat, b0);
    e = ref_mul(x, x);
    check(r == e, "R2 x^190 squared via mul", r, e);
    run_op(2'b01, '1, '1, r, lat, b0);
    e = ref_mul('1, '1);
    check(r == e, "R2 all ones", r, e);
    run_op(2'b01, rnd191(), '0, r, lat, b0);
    check(r == '0, "R2 zero operand", r, '0);

    // R2 random
    for (int n = 0; n < 30; n++) begin
      x = rnd191(); y = rnd191();
      run_op(2'b01, x, y, r, lat, b0);
      e = ref_mul(x, y);
      check(r == e, "R2 random product", r, e);
      check(lat == ND + 1, "R3 random latency", 191'(lat), 191'(ND + 1));
    end

    // R4 squaring vs reference and vs own multiply
    for (int n = 0; n < 12; n++) begin
      x = (n == 0) ? (191'b1 << 190) : rnd191();
      run_op(2'b10, x, rnd191(), r, lat, b0);
      e = ref_mul(x, x);
      check(r == e, "R4 square value", r, e);
      check(lat == 0 && b0 == 1'b0, "R4 single cycle", 191'(lat), '0);
      run_op(2'b01, x, x, r2, lat, b0);
      check(r2 == r, "R4 square equals self multiply", r2, r);
    end

    // R5 addition
    for (int n = 0; n < 10; n++) begin
      x = rnd191(); y = rnd191();
      run_op(2'b00, x, y, r, lat, b0);
      check(r == (x ^ y), "R5 xor sum", r, x ^ y);
      check(lat == 0 && b0 == 1'b0, "R5 single cycle", 191'(lat), '0);
    end

    // R6 pulse width and hold
    held = result;
    @(negedge clk);
    check(!done, "R6 done one cycle", 191'(done), '0);
    repeat (4) @(negedge clk);
    check(result == held, "R6 result held", result, held);

    // R7 start ignored while busy, R9 operands captured
    x = rnd191(); y = rnd191();
    @(negedge clk);
    start = 1'b1; op = 2'b01; a = x; b = y;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1; op = 2'b00; a = rnd191(); b = rnd191();
    @(negedge clk);
    start = 1'b0;
    a = ~x; b = ~y;
    lat = 4;
    while (!done && lat < 2000) begin @(negedge clk); lat++; end
    e = ref_mul(x, y);
    check(result == e, "R9 captured operands", result, e);
    check(lat == ND + 1, "R7 latency unchanged", 191'(lat), 191'(ND + 1));
    quiet = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (done || busy) quiet = 1'b0;
    end
    check(quiet && result == e, "R7 no extra command", result, e);

    // R8 reserved opcode
    held = result;
    @(negedge clk);
    start = 1'b1; op = 2'b11; a = rnd191(); b = rnd191();
    @(negedge clk);
    start = 1'b0;
    quiet = !busy && !done;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (done || busy) quiet = 1'b0;
    end
    check(quiet, "R8 reserved no handshake", 191'(quiet), 191'd1);
    check(result == held, "R8 reserved result unchanged", result, held);

    summary();
    $finish;
  end
endmodule